// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or silently discarded, using only the frame's 48-bit destination address and its length. The receive path raises a one-cycle check strobe while the address, the length, the enable bits, the two station addresses and the 64-bit hash table are stable on the inputs. One cycle later the block presents a registered keep/drop answer together with a one-cycle valid pulse.

There are three ways to accept a frame. The first is an exact match against either of two programmable station addresses. The second is the all-ones broadcast address. The third is a hit in a 64-entry table indexed by a 6-bit XOR fold of the whole address. The fold is normally used only for group (multicast) addresses. An enable bit also applies it to individual addresses. Frames shorter than the minimum length are refused whatever their address.

Control follows a two-state machine. ST_IDLE waits for a check. ST_REPORT holds the answer on the outputs for one cycle. Transition T_LAUNCH (ST_IDLE to ST_REPORT) fires on the strobe. T_CHAIN (ST_REPORT to ST_REPORT) fires on a strobe that arrives while an answer is showing. T_RETIRE (ST_REPORT to ST_IDLE) fires when no strobe arrives.

Top module: `rxf_dest_filter`

## Requirements
- R1: A check strobe in cycle N makes `dec_valid` high in cycle N+1 only. Strobes in consecutive cycles give consecutive valid cycles, each carrying the answer for its own inputs.
- R2: During and after reset, `dec_valid` and `dec_accept` are 0. `dec_accept` is 0 in every cycle where `dec_valid` is 0.
- R3: A frame whose length is below 12 bytes is dropped even when its address would match. A length of exactly 12 is judged on the address.
- R4: Station address 0 is given as a 32-bit low word holding bytes 0 to 3 (byte 0 in bits 7:0) and a 16-bit high word holding bytes 4 and 5 (byte 4 in bits 7:0). When `filt_ctrl` bit 0 is set, a destination equal to it is accepted.
- R5: Station address 1 has the same layout and is enabled by `filt_ctrl` bit 1. A station address whose enable bit is clear has no effect, even on an exact match.
- R6: When `filt_ctrl` bit 3 is set, the destination FF:FF:FF:FF:FF:FF is accepted. With bit 3 clear and no table bit set, it is dropped.
- R7: The destination is given with byte 0 in bits 7:0. The group bit is bit 0 of byte 0. The hash is the XOR of the eight 6-bit slices of the 48-bit address, taken from bit 0 upward. The table is consulted whenever the group bit is set.
- R8: Hash value h selects bit h of `hash_tbl`: values 0 to 31 fall in the low word (bits 31:0) and values 32 to 63 fall in the high word at bit h-32. The frame is accepted through the table only if that bit is 1.
- R9: For an individual address (group bit 0), the table is consulted only when `filt_ctrl` bit 2 is set.
- R10: A frame with no enabled station match, no enabled broadcast match and no table hit is dropped: `dec_accept` is 0 during its valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_start | input | 1 | One-cycle strobe: evaluate the current inputs |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| filt_ctrl | input | 4 | Bit 0/1: station 0/1 enable, bit 2: hash individual addresses, bit 3: broadcast enable |
| stn_lo | input | 2x32 | Low words of the station addresses (bytes 0 to 3) |
| stn_hi | input | 2x16 | High words of the station addresses (bytes 4 and 5) |
| hash_tbl | input | 64 | Hash table, bit h for hash value h |
| dec_valid | output | 1 | One-cycle pulse marking the answer |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
Every answer is due exactly one clock after its strobe, because a single register level lies between the inputs and `dec_valid`/`dec_accept`. The bench drives the inputs and the strobe on the falling edge. It samples the outputs on the next falling edge, where the answer must be showing, and on the falling edge after that, where the valid pulse must have ended. The back-to-back case samples two consecutive falling edges to confirm that each answer belongs to its own strobe. Expected values, including the fold of each test address, are computed in the bench bit by bit from the requirements.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // Control-state encoding for the decision sequencer
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rxf_state_e;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned ADDR_W   = BYTE_W * ADDR_BYTES;
    localparam int unsigned LO_W     = 32;
    localparam int unsigned HI_W     = ADDR_W - LO_W;
endpackage

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
    parameter int unsigned IN_W   = 48,
    parameter int unsigned HASH_W = 6
) (
    input  logic [IN_W-1:0]   vec_in,
    output logic [HASH_W-1:0] fold_out
);
    localparam int unsigned SLICES = (IN_W + HASH_W - 1) / HASH_W;
    localparam int unsigned PAD_W  = SLICES * HASH_W;

    logic [PAD_W-1:0]  padded;
    logic [HASH_W-1:0] part [SLICES];

    assign padded = PAD_W'(vec_in);

    // Running XOR chain across slices, lowest bits first
    generate
        for (genvar k = 0; k < SLICES; k++) begin : g_slice
            if (k == 0) begin : g_first
                assign part[k] = padded[HASH_W-1:0];
            end else begin : g_rest
                assign part[k] = part[k-1] ^ padded[k*HASH_W +: HASH_W];
            end
        end
    endgenerate

    assign fold_out = part[SLICES-1];
endmodule

// File: rtl/rxf_stn_match.sv
module rxf_stn_match #(
    parameter int unsigned NUM_STN = 2
) (
    input  logic [rxf_pkg::ADDR_W-1:0]              dst,
    input  logic [NUM_STN-1:0][rxf_pkg::LO_W-1:0]   lo_words,
    input  logic [NUM_STN-1:0][rxf_pkg::HI_W-1:0]   hi_words,
    input  logic [NUM_STN-1:0]                      slot_en,
    output logic                                    any_hit
);
    logic [NUM_STN-1:0] slot_hit;

    generate
        for (genvar s = 0; s < NUM_STN; s++) begin : g_slot
            logic [rxf_pkg::ADDR_W-1:0] stn_addr;
            assign stn_addr    = {hi_words[s], lo_words[s]};
            assign slot_hit[s] = slot_en[s] && (stn_addr == dst);
        end
    endgenerate

    assign any_hit = |slot_hit;
endmodule

// File: rtl/rxf_ctrl_fsm.sv
module rxf_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic verdict,
    output logic out_valid,
    output logic out_accept
);
    import rxf_pkg::*;

    rxf_state_e state_q, state_d;
    logic       verdict_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Verdict captured with the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= 1'b0;
        end else if (start) begin
            verdict_q <= verdict;
        end
    end

    // Next state: T_LAUNCH, T_CHAIN, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = start ? ST_REPORT : ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid  = 1'b0;
        out_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid  = 1'b0;
                out_accept = 1'b0;
            end
            ST_REPORT: begin
                out_valid  = 1'b1;
                out_accept = verdict_q;
            end
        endcase
    end
endmodule

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter #(
    parameter int unsigned NUM_STN = 2,
    parameter int unsigned HASH_W  = 6,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MIN_LEN = 12,
    localparam int unsigned TBL_W  = 1 << HASH_W,
    localparam int unsigned CTRL_W = NUM_STN + 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  chk_start,
    input  logic [rxf_pkg::ADDR_W-1:0]            dst_addr,
    input  logic [LEN_W-1:0]                      frame_len,
    input  logic [CTRL_W-1:0]                     filt_ctrl,
    input  logic [NUM_STN-1:0][rxf_pkg::LO_W-1:0] stn_lo,
    input  logic [NUM_STN-1:0][rxf_pkg::HI_W-1:0] stn_hi,
    input  logic [TBL_W-1:0]                      hash_tbl,
    output logic                                  dec_valid,
    output logic                                  dec_accept
);
    localparam int unsigned IND_BIT = NUM_STN;
    localparam int unsigned BC_BIT  = NUM_STN + 1;

    logic              len_ok;
    logic              stn_hit;
    logic              bc_hit;
    logic              grp_bit;
    logic              tbl_gate;
    logic              tbl_hit;
    logic [HASH_W-1:0] hidx;
    logic              verdict;

    assign len_ok  = frame_len >= LEN_W'(MIN_LEN);
    assign grp_bit = dst_addr[0];
    assign bc_hit  = filt_ctrl[BC_BIT] && (&dst_addr);

    rxf_stn_match #(
        .NUM_STN (NUM_STN)
    ) u_stn (
        .dst      (dst_addr),
        .lo_words (stn_lo),
        .hi_words (stn_hi),
        .slot_en  (filt_ctrl[NUM_STN-1:0]),
        .any_hit  (stn_hit)
    );

    rxf_hash_fold #(
        .IN_W   (rxf_pkg::ADDR_W),
        .HASH_W (HASH_W)
    ) u_fold (
        .vec_in   (dst_addr),
        .fold_out (hidx)
    );

    assign tbl_gate = grp_bit || filt_ctrl[IND_BIT];
    assign tbl_hit  = tbl_gate && hash_tbl[hidx];
    assign verdict  = len_ok && (stn_hit || bc_hit || tbl_hit);

    rxf_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (chk_start),
        .verdict    (verdict),
        .out_valid  (dec_valid),
        .out_accept (dec_accept)
    );
endmodule

// File: rtl/rxf_dest_filter_chk.sv
module rxf_dest_filter_chk #(
    parameter int unsigned NUM_STN = 2,
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MIN_LEN = 12,
    parameter int unsigned CTRL_W  = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  chk_start,
    input logic [rxf_pkg::ADDR_W-1:0]            dst_addr,
    input logic [LEN_W-1:0]                      frame_len,
    input logic [CTRL_W-1:0]                     filt_ctrl,
    input logic [NUM_STN-1:0][rxf_pkg::LO_W-1:0] stn_lo,
    input logic [NUM_STN-1:0][rxf_pkg::HI_W-1:0] stn_hi,
    input logic                                  dec_valid,
    input logic                                  dec_accept
);
    localparam int unsigned BC_BIT = NUM_STN + 1;

    p_valid_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |=> dec_valid);

    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_start |=> !dec_valid);

    p_accept_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    p_short_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_start && frame_len < LEN_W'(MIN_LEN)) |=> !dec_accept);

    p_stn0_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_start && frame_len >= LEN_W'(MIN_LEN) && filt_ctrl[0]
         && dst_addr == {stn_hi[0], stn_lo[0]}) |=> dec_accept);

    p_bcast_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_start && frame_len >= LEN_W'(MIN_LEN) && filt_ctrl[BC_BIT]
         && (&dst_addr)) |=> dec_accept);

    p_nothing_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_start && filt_ctrl == '0 && !dst_addr[0]) |=> !dec_accept);
endmodule

bind rxf_dest_filter rxf_dest_filter_chk #(
    .NUM_STN (NUM_STN),
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .CTRL_W  (CTRL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_start  (chk_start),
    .dst_addr   (dst_addr),
    .frame_len  (frame_len),
    .filt_ctrl  (filt_ctrl),
    .stn_lo     (stn_lo),
    .stn_hi     (stn_hi),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
);

// File: tb/test_rxf_dest_filter.sv
`timescale 1ns/1ps
module test_rxf_dest_filter;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chk_start = 1'b0;
    logic [47:0]       dst_addr = '0;
    logic [15:0]       frame_len = '0;
    logic [3:0]        filt_ctrl = '0;
    logic [1:0][31:0]  stn_lo = '0;
    logic [1:0][15:0]  stn_hi = '0;
    logic [63:0]       hash_tbl = '0;
    logic              dec_valid;
    logic              dec_accept;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [47:0] STA0 = 48'h6655_4433_2210;
    localparam logic [47:0] STA1 = 48'hA0B0_C0D0_E0F2;
    localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    rxf_dest_filter i_rxf_dest_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_start  (chk_start),
        .dst_addr   (dst_addr),
        .frame_len  (frame_len),
        .filt_ctrl  (filt_ctrl),
        .stn_lo     (stn_lo),
        .stn_hi     (stn_hi),
        .hash_tbl   (hash_tbl),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    // Bench model of the fold: bit i of the address goes to hash bit i mod 6
    function automatic int fold6(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int i = 0; i < 48; i++) h[i % 6] = h[i % 6] ^ a[i];
        return int'(h);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Launch one check and verify the answer and the end of the pulse
    task automatic judge(input logic [47:0] da, input logic [15:0] len,
                         input logic [3:0] ctl, input bit exp, input string req);
        @(negedge clk);
        dst_addr = da; frame_len = len; filt_ctrl = ctl; chk_start = 1'b1;
        @(negedge clk);
        chk_start = 1'b0;
        check(dec_valid === 1'b1, req, "valid", int'(dec_valid), 1);
        check(dec_accept === exp, req, "accept", int'(dec_accept), int'(exp));
        @(negedge clk);
        check(dec_valid === 1'b0 && dec_accept === 1'b0, req, "pulse end",
              int'({dec_valid, dec_accept}), 0);
    endtask

    task automatic t_reset;
        check(dec_valid === 1'b0, "R2", "valid in reset", int'(dec_valid), 0);
        check(dec_accept === 1'b0, "R2", "accept in reset", int'(dec_accept), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid === 1'b0 && dec_accept === 1'b0, "R2", "idle after reset",
              int'({dec_valid, dec_accept}), 0);
    endtask

    task automatic t_stations;
        stn_lo[0] = STA0[31:0]; stn_hi[0] = STA0[47:32];
        stn_lo[1] = STA1[31:0]; stn_hi[1] = STA1[47:32];
        hash_tbl = '0;
        judge(STA0, 16'd64, 4'b0001, 1'b1, "R4");
        judge(STA0 ^ 48'h0100_0000_0000, 16'd64, 4'b0001, 1'b0, "R4");
        judge(STA1, 16'd64, 4'b0010, 1'b1, "R5");
        judge(STA1, 16'd64, 4'b0001, 1'b0, "R5");
        judge(STA0, 16'd64, 4'b0010, 1'b0, "R5");
    endtask

    task automatic t_broadcast;
        hash_tbl = '0;
        judge(BCST, 16'd60, 4'b1000, 1'b1, "R6");
        judge(BCST, 16'd60, 4'b0011, 1'b0, "R6");
    endtask

    task automatic t_short;
        judge(STA0, 16'd11, 4'b1111, 1'b0, "R3");
        judge(BCST, 16'd0, 4'b1000, 1'b0, "R3");
        judge(STA0, 16'd12, 4'b0001, 1'b1, "R3");
    endtask

    task automatic t_hash_group;
        logic [47:0] grp [3];
        grp[0] = 48'h0000_0000_0001;
        grp[1] = 48'h0000_0000_0021;
        grp[2] = 48'h3355_77AA_CC01;
        for (int g = 0; g < 3; g++) begin
            int h = fold6(grp[g]);
            hash_tbl = 64'd1 << h;
            judge(grp[g], 16'd64, 4'b0000, 1'b1, (h > 31) ? "R8" : "R7");
            hash_tbl = ~(64'd1 << h);
            judge(grp[g], 16'd64, 4'b0000, 1'b0, "R8");
        end
    endtask

    task automatic t_hash_individual;
        logic [47:0] ind = 48'h1234_5678_9A22;
        int h = fold6(ind);
        hash_tbl = 64'd1 << h;
        judge(ind, 16'd64, 4'b0100, 1'b1, "R9");
        judge(ind, 16'd64, 4'b0000, 1'b0, "R9");
    endtask

    task automatic t_nomatch;
        hash_tbl = '0;
        judge(48'h0102_0304_0506, 16'd1500, 4'b1111, 1'b0, "R10");
    endtask

    task automatic t_back_to_back;
        hash_tbl = '0;
        @(negedge clk);
        dst_addr = STA0; frame_len = 16'd64; filt_ctrl = 4'b0001; chk_start = 1'b1;
        @(negedge clk);
        check(dec_valid === 1'b1 && dec_accept === 1'b1, "R1", "first answer",
              int'({dec_valid, dec_accept}), 3);
        dst_addr = STA1;
        @(negedge clk);
        chk_start = 1'b0;
        check(dec_valid === 1'b1 && dec_accept === 1'b0, "R1", "second answer",
              int'({dec_valid, dec_accept}), 2);
        @(negedge clk);
        check(dec_valid === 1'b0, "R1", "pulse end", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_stations();
        t_broadcast();
        t_short();
        t_hash_group();
        t_hash_individual();
        t_nomatch();
        t_back_to_back();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule